// File: doc/BRIEF.md
# Multi-ring receive descriptor pointer unit

This block holds, for each of eight receive descriptor rings, a software-programmed base address and a hardware-maintained current descriptor pointer. Software writes and reads the base registers through a simple register port and can read every current pointer there. Writes aimed at a pointer are dropped. The receive DMA engine picks a ring with a select input and signals each descriptor it has closed, together with that descriptor's wrap flag. The block then moves the ring's pointer one 8-byte descriptor forward, or back to the ring's base when the wrap flag is set. The DMA side always sees the pointer of the ring it selects.

Each ring has its own enable input and runs a two-state controller. `RING_OFF` is the reset state, and the ring is idle in it. When the ring's enable is high, the controller takes transition *arm* to `RING_RUN` and loads the pointer from the base in the same clock. In `RING_RUN` a close moves the pointer on (transition *step*, no wrap) or reloads it from the base (transition *wrap*). When the enable drops, the controller takes transition *disarm* back to `RING_OFF` and the pointer holds its value. A close never acts on a ring that is in `RING_OFF`, or on one whose enable is low in that cycle.

Top module: `rx_ring_ptr_unit`

## Requirements
- R1: After reset every base register and every current pointer reads 0x0000_0000.
- R2: A base write stores bits 31:3 of the write data, and bits 2:0 always store as zero.
- R3: Bits 2:0 of every pointer read as zero. A software write to a pointer address (sw_addr[3]=1) leaves that pointer unchanged.
- R4: On a running ring with its enable high, a close with dma_wrap=0 adds 8 to the pointer. The new value is visible from the cycle after the close edge.
- R5: On a running ring with its enable high, a close with dma_wrap=1 loads the pointer with that ring's base.
- R6: A close on a ring whose enable is low leaves that ring's pointer unchanged.
- R7: In the first clock edge at which a ring's enable is high while the ring is idle, the pointer is loaded from the base.
- R8: If a base write and a close on the same ring fall on the same clock edge, the pointer update uses the base value from before the write.
- R9: dma_ptr always shows the current pointer of the ring chosen by dma_sel. sw_rdata shows the base (sw_addr[3]=0) or the pointer (sw_addr[3]=1) of the ring sw_addr[2:0].
- R10: A close or base write on one ring does not change the base or pointer of any other ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 4 | Bit 3: 0 = base, 1 = pointer; bits 2:0: ring |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| ring_en | input | 8 | Per-ring receive enable, bit n for ring n |
| dma_sel | input | 3 | Ring addressed by the DMA side |
| dma_close | input | 1 | Descriptor closed on ring dma_sel |
| dma_wrap | input | 1 | Wrap flag of the closed descriptor |
| dma_ptr | output | 32 | Current pointer of ring dma_sel |

## Verification
A short directed sequence comes first. It exercises plain steps, a wrap reload, a close on a disabled ring, a pointer write attempt and a base write in the same cycle as a wrap close. Each of these leaves a different pointer value, so a wrong reload source, a missing guard or a wrong step size can be told apart. A long pseudo-random phase follows, in which enables toggle, closes, wraps and writes arrive on random rings, and misaligned data is written. Every cycle the bench compares both read paths with a behavioural model. This catches cross-ring leakage, a wrong select and wrong ordering of writes and updates, all of which the directed part touches only once.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    localparam int unsigned RING_CNT   = 8;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned ALIGN_W    = $clog2(DESC_BYTES);
    localparam int unsigned SEL_W      = $clog2(RING_CNT);

    typedef enum logic {
        RING_OFF = 1'b0,
        RING_RUN = 1'b1
    } ring_state_e;
endpackage

// File: rtl/ring_slot.sv
module ring_slot
    import rx_ring_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned STEP  = DESC_BYTES,
    parameter int unsigned LOW_W = ALIGN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          base_we_i,
    input  logic [AW-1:0] base_wd_i,
    input  logic          close_i,
    input  logic          wrap_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    ring_state_e   state_q, state_d;
    logic [AW-1:0] base_q;
    logic [AW-1:0] ptr_q, ptr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RING_OFF;
        else        state_q <= state_d;
    end

    // transitions: arm, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RING_OFF: if (en_i)  state_d = RING_RUN;
            RING_RUN: if (!en_i) state_d = RING_OFF;
            default:             state_d = RING_OFF;
        endcase
    end

    // output process: pointer next value
    always_comb begin
        ptr_d = ptr_q;
        unique case (state_q)
            RING_OFF: if (en_i) ptr_d = base_q;
            RING_RUN: begin
                if (en_i && close_i) ptr_d = wrap_i ? base_q : ptr_q + STEP_V;
            end
            default: ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            if (base_we_i) base_q <= {base_wd_i[AW-1:LOW_W], {LOW_W{1'b0}}};
        end
    end

    assign base_o = base_q;
    assign ptr_o  = ptr_q;

    // R2
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_i |=> base_q[LOW_W-1:0] == '0);
    // R3
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[LOW_W-1:0] == '0);
    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RING_RUN && en_i && close_i && !wrap_i) |=> ptr_q == $past(ptr_q) + STEP_V);
    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RING_RUN && en_i && close_i && wrap_i) |=> ptr_q == $past(base_q));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> $stable(ptr_q));
    // R7
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RING_OFF && en_i) |=> ptr_q == $past(base_q));
endmodule

// File: rtl/ring_read_mux.sv
module ring_read_mux
    import rx_ring_pkg::*;
#(
    parameter int unsigned N  = RING_CNT,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic [N-1:0][AW-1:0] base_all_i,
    input  logic [N-1:0][AW-1:0] ptr_all_i,
    input  logic                 pick_ptr_i,
    input  logic [SW-1:0]        sw_ring_i,
    input  logic [SW-1:0]        dma_ring_i,
    output logic [AW-1:0]        sw_rdata_o,
    output logic [AW-1:0]        dma_ptr_o
);
    always_comb begin
        sw_rdata_o = pick_ptr_i ? ptr_all_i[sw_ring_i] : base_all_i[sw_ring_i];
        dma_ptr_o  = ptr_all_i[dma_ring_i];
    end
endmodule

// File: rtl/rx_ring_ptr_unit.sv
module rx_ring_ptr_unit
    import rx_ring_pkg::*;
#(
    parameter int unsigned N  = RING_CNT,
    parameter int unsigned AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_wr,
    input  logic [$clog2(N):0]    sw_addr,
    input  logic [AW-1:0]         sw_wdata,
    output logic [AW-1:0]         sw_rdata,
    input  logic [N-1:0]          ring_en,
    input  logic [$clog2(N)-1:0]  dma_sel,
    input  logic                  dma_close,
    input  logic                  dma_wrap,
    output logic [AW-1:0]         dma_ptr
);
    localparam int unsigned SW = $clog2(N);

    logic [N-1:0][AW-1:0] base_all;
    logic [N-1:0][AW-1:0] ptr_all;
    logic                 pick_ptr;
    logic [SW-1:0]        sw_ring;

    assign pick_ptr = sw_addr[SW];
    assign sw_ring  = sw_addr[SW-1:0];

    for (genvar g = 0; g < N; g++) begin : g_ring
        logic we_g, close_g;
        assign we_g    = sw_wr && !pick_ptr && (sw_ring == SW'(g));
        assign close_g = dma_close && (dma_sel == SW'(g));

        ring_slot #(.AW(AW), .STEP(DESC_BYTES), .LOW_W(ALIGN_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ring_en[g]),
            .base_we_i (we_g),
            .base_wd_i (sw_wdata),
            .close_i   (close_g),
            .wrap_i    (dma_wrap),
            .base_o    (base_all[g]),
            .ptr_o     (ptr_all[g])
        );

        // R10
        other_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!close_g && ring_en[g] && $past(ring_en[g]) && rst_n && $past(rst_n))
                |=> $stable(ptr_all[g]) || $past(close_g));
    end

    ring_read_mux #(.N(N), .AW(AW), .SW(SW)) i_mux (
        .base_all_i (base_all),
        .ptr_all_i  (ptr_all),
        .pick_ptr_i (pick_ptr),
        .sw_ring_i  (sw_ring),
        .dma_ring_i (dma_sel),
        .sw_rdata_o (sw_rdata),
        .dma_ptr_o  (dma_ptr)
    );

    // R3
    ptr_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && pick_ptr && !dma_close && ring_en == $past(ring_en)) |=> $stable(ptr_all));
endmodule

// File: tb/test_rx_ring_ptr_unit.sv
module test_rx_ring_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr;
    logic [3:0]  sw_addr;
    logic [31:0] sw_wdata;
    logic [31:0] sw_rdata;
    logic [7:0]  ring_en;
    logic [2:0]  dma_sel;
    logic        dma_close;
    logic        dma_wrap;
    logic [31:0] dma_ptr;

    always #10 clk = ~clk;

    rx_ring_ptr_unit i_rx_ring_ptr_unit (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .ring_en(ring_en),
        .dma_sel(dma_sel), .dma_close(dma_close), .dma_wrap(dma_wrap),
        .dma_ptr(dma_ptr)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_base [8];
    logic [31:0] m_ptr  [8];
    bit          m_on   [8];
    logic [31:0] rng = 32'h1ACE_B00C;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference, evaluated at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin m_base[r] = 0; m_ptr[r] = 0; m_on[r] = 0; end
        end else begin
            for (int r = 0; r < 8; r++) begin
                if (m_on[r]) begin
                    if (!ring_en[r]) m_on[r] = 0;
                    else if (dma_close && dma_sel == 3'(r))
                        m_ptr[r] = dma_wrap ? m_base[r] : m_ptr[r] + 32'd8;
                end else if (ring_en[r]) begin
                    m_on[r]  = 1;
                    m_ptr[r] = m_base[r];
                end
            end
            if (sw_wr && !sw_addr[3]) m_base[sw_addr[2:0]] = sw_wdata & 32'hFFFF_FFF8;
        end
    end

    // compare both read paths against the model after each edge
    task automatic cmp_all();
        chk("R9 dma_ptr", dma_ptr, m_ptr[dma_sel]);
        chk(sw_addr[3] ? "R3 sw ptr read" : "R2 sw base read", sw_rdata,
            sw_addr[3] ? m_ptr[sw_addr[2:0]] : m_base[sw_addr[2:0]]);
    endtask

    task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                       input logic [7:0] en, input logic [2:0] s,
                       input bit cl, input bit wp);
        sw_wr = wr; sw_addr = a; sw_wdata = d; ring_en = en;
        dma_sel = s; dma_close = cl; dma_wrap = wp;
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        sw_wr = 0; dma_close = 0; sw_addr = a;
        #1 v = sw_rdata;
    endtask

    bit done = 0;
    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 0; sw_wr = 0; sw_addr = 0; sw_wdata = 0; ring_en = 0;
        dma_sel = 0; dma_close = 0; dma_wrap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            peek(4'(a), v);
            chk("R1 reset value", v, 32'h0);
        end
        // R2 misaligned base write
        cyc(1, 4'h3, 32'h1000_0007, 8'h00, 3'd3, 0, 0);
        peek(4'h3, v); chk("R2 low bits cleared", v, 32'h1000_0000);
        // R3 pointer write dropped
        cyc(1, 4'hB, 32'hFFFF_FFFF, 8'h00, 3'd3, 0, 0);
        peek(4'hB, v); chk("R3 ptr write ignored", v, 32'h0);
        // R7 enable rise loads base
        cyc(0, 4'hB, 0, 8'h08, 3'd3, 0, 0);
        chk("R7 arm load", dma_ptr, 32'h1000_0000);
        // R4 three steps
        for (int k = 0; k < 3; k++) cyc(0, 4'hB, 0, 8'h08, 3'd3, 1, 0);
        chk("R4 step by 8", dma_ptr, 32'h1000_0018);
        // R5 wrap reload
        cyc(0, 4'hB, 0, 8'h08, 3'd3, 1, 1);
        chk("R5 wrap to base", dma_ptr, 32'h1000_0000);
        // R6 close on disabled ring 5
        cyc(1, 4'h5, 32'h5000_0000, 8'h08, 3'd5, 0, 0);
        cyc(0, 4'hD, 0, 8'h08, 3'd5, 1, 0);
        chk("R6 disabled ring unchanged", dma_ptr, 32'h0);
        // R10 ring 3 untouched by ring 5 traffic
        peek(4'hB, v); chk("R10 other ring intact", v, 32'h1000_0000);
        // R8 same-edge base write and wrap close
        cyc(0, 4'hB, 0, 8'h08, 3'd3, 1, 0);
        cyc(1, 4'h3, 32'h2000_0000, 8'h08, 3'd3, 1, 1);
        chk("R8 old base used", dma_ptr, 32'h1000_0000);
        peek(4'h3, v); chk("R8 new base stored", v, 32'h2000_0000);
        // R6 disarm then close, then rearm reloads new base (R7)
        cyc(0, 4'hB, 0, 8'h00, 3'd3, 1, 0);
        chk("R6 close after disarm", dma_ptr, 32'h1000_0000);
        cyc(0, 4'hB, 0, 8'h08, 3'd3, 0, 0);
        chk("R7 rearm load", dma_ptr, 32'h2000_0000);
        // random phase, compared every cycle
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r1, r2;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            r1 = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            r2 = rng;
            cyc(r1[0] & r1[1], r1[7:4], r2,
                (r1[12:10] == 3'd0) ? ring_en ^ r1[23:16] : ring_en,
                r1[26:24], r1[27] | r1[28], r1[29] & r1[30] & r1[31]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule